// File: doc/BRIEF.md
# Field-Programmable Sum-of-Products Logic Array

This block is a small programmable combinational logic array. A plane of product terms forms ANDs over a set of literals (each source offered both true and inverted). A second plane ORs chosen product terms into each output. Every output then passes through a programmable inverter, and the first few outputs sit on bidirectional pins. A disabled pin stops driving. Its external value then becomes an extra source for the product terms. An enabled pin feeds its own driven value back instead.

The whole configuration is one serial word, shifted in one bit per clock while the load strobe is high. A compile-time mode picks the variant: both planes programmable, a fixed full minterm decoder with only the OR plane programmable, or programmable product terms with a fixed OR grouping. The serial input behaves like a stream whose `cfg_load` is the valid flag. It has no ready: every bit presented with `cfg_load` high is taken on that clock edge, so there is never back-pressure.

Top module: `pla_array`

## Requirements
- R1: On each rising clock edge with `cfg_load` high, `cfg_bit` enters bit 0 of the configuration word and the other bits move up by one. The first bit sent therefore ends at the most significant position after `CFG_LEN` bits.
- R2: From reset until `CFG_LEN` bits have been shifted in, every `pin_oe` and `pin_do` bit is 0 (Z). Once the count is reached, the word takes effect from the clock edge that took the last bit.
- R3: While `cfg_load` is low, the configuration word does not change, whatever `cfg_bit` does.
- R4: Sources are numbered with `ded_in[i]` as source i and pin j as source `N_IN+j`. Literal 2s is source s and literal 2s+1 is its inverse. AND bit `t*2*(N_IN+N_IO)+l` connects literal l to term t. A term is the AND of its connected literals. A term with one literal is that literal, and a term with none is 0.
- R5: OR bit `AND_BITS+t*N_OUT+k` connects term t to output k, and output k is the OR of its connected terms. One term may feed several outputs.
- R6: Polarity bit `AND_BITS+OR_BITS+k` set to 1 inverts output k; 0 leaves it true.
- R7: Enable bit `AND_BITS+OR_BITS+N_OUT+j` set to 1 drives pin j (`pin_oe[j]`=1, `pin_do[j]` = function). When it is 0, both are 0. Outputs at index `N_IO` and above are always driven once loaded.
- R8: For a pin that is not driven, the source for the product terms is `pin_di[j]`, with no delay.
- R9: For a driven pin, the source is the value `pin_do[j]` held at the previous rising edge, and `pin_di[j]` is ignored.
- R10: In decoder mode there are no AND bits and `2**(N_IN+N_IO)` terms. Term m is true exactly when the source vector (source s as bit s) equals m.
- R11: In fixed-OR mode there are no OR bits, and term t feeds only output `t % N_OUT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Shift strobe (valid) for the serial configuration |
| cfg_bit | input | 1 | Serial configuration bit, first bit sent is the MSB |
| ded_in | input | N_IN | Dedicated logic inputs |
| pin_di | input | N_IO | External value seen on each bidirectional pin |
| pin_do | output | N_OUT | Value driven on each output, 0 when not driven |
| pin_oe | output | N_OUT | Drive enable per output; 0 means the pin is Z |

## Verification
Configuration bits count at the rising edge where they are sampled. Outputs switch on from that same edge as the last bit. Function values follow `ded_in`, `pin_di` and the configuration with no register in the path. The exception is feedback from a driven pin, which arrives one rising edge after the pin's value. The bench changes inputs on the falling edge and samples 1 ns later, which is before the next rising edge. A combinational result is therefore read in the same half-cycle, and a feedback result is read one falling edge later.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic [1:0] {
    PLANE_BOTH = 2'd0,
    PLANE_ROM  = 2'd1,
    PLANE_PAL  = 2'd2
  } plane_mode_e;
endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int LEN = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           shift_bit,
  output logic [LEN-1:0] word,
  output logic           loaded
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      cnt  <= '0;
    end else if (shift_en) begin
      word <= {word[LEN-2:0], shift_bit};
      if (cnt != CW'(LEN)) cnt <= cnt + 1'b1;
    end
  end

  assign loaded = (cnt == CW'(LEN));

  AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word)); // R3
  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> word[0] == $past(shift_bit)); // R1
  AST_LOAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> loaded); // R2
  AST_LOAD_BY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded) |-> $past(shift_en)); // R1
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_SRC = 6,
  parameter int NT    = 8
) (
  input  logic [N_SRC-1:0]      src,
  input  logic [NT*2*N_SRC-1:0] conn,
  output logic [NT-1:0]         term
);
  localparam int N_LIT = 2 * N_SRC;

  logic [N_LIT-1:0] lit;

  for (genvar s = 0; s < N_SRC; s++) begin : g_lit
    assign lit[2*s]   = src[s];
    assign lit[2*s+1] = ~src[s];
  end

  for (genvar t = 0; t < NT; t++) begin : g_term
    logic [N_LIT-1:0] row;
    assign row     = conn[t*N_LIT +: N_LIT];
    assign term[t] = (|row) & (&(lit | ~row));
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int NT    = 8,
  parameter int N_OUT = 3
) (
  input  logic [NT-1:0]       term,
  input  logic [NT*N_OUT-1:0] conn,
  input  logic [N_OUT-1:0]    pol,
  output logic [N_OUT-1:0]    f
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_sum
    logic [NT-1:0] col;
    for (genvar t = 0; t < NT; t++) begin : g_col
      assign col[t] = conn[t*N_OUT + k];
    end
    assign f[k] = (|(term & col)) ^ pol[k];
  end
endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int N_IN  = 4,
  parameter int N_IO  = 2,
  parameter int N_PT  = 8,
  parameter int N_OUT = 3,
  parameter pla_pkg::plane_mode_e MODE = pla_pkg::PLANE_BOTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic             cfg_bit,
  input  logic [N_IN-1:0]  ded_in,
  input  logic [N_IO-1:0]  pin_di,
  output logic [N_OUT-1:0] pin_do,
  output logic [N_OUT-1:0] pin_oe
);
  import pla_pkg::*;

  localparam int N_SRC    = N_IN + N_IO;
  localparam int N_LIT    = 2 * N_SRC;
  localparam int NT       = (MODE == PLANE_ROM) ? (1 << N_SRC) : N_PT;
  localparam int AND_BITS = (MODE == PLANE_ROM) ? 0 : NT * N_LIT;
  localparam int OR_BITS  = (MODE == PLANE_PAL) ? 0 : NT * N_OUT;
  localparam int POL_OFF  = AND_BITS + OR_BITS;
  localparam int EN_OFF   = POL_OFF + N_OUT;
  localparam int CFG_LEN  = EN_OFF + N_IO;

  logic [CFG_LEN-1:0]  cfg_word;
  logic                loaded;
  logic [N_OUT-1:0]    pol_bits;
  logic [N_IO-1:0]     en_bits;
  logic [N_OUT-1:0]    drive_en;
  logic [N_IO-1:0]     fb_q;
  logic [N_IO-1:0]     pin_src;
  logic [N_SRC-1:0]    src;
  logic [NT*N_LIT-1:0] and_conn;
  logic [NT*N_OUT-1:0] or_conn;
  logic [NT-1:0]       term;
  logic [N_OUT-1:0]    f_val;

  pla_cfg_chain #(.LEN(CFG_LEN)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (cfg_load),
    .shift_bit (cfg_bit),
    .word      (cfg_word),
    .loaded    (loaded)
  );

  assign pol_bits = cfg_word[POL_OFF +: N_OUT];
  assign en_bits  = cfg_word[EN_OFF +: N_IO];

  if (MODE == PLANE_ROM) begin : g_and_fixed
    for (genvar m = 0; m < NT; m++) begin : g_min
      for (genvar s = 0; s < N_SRC; s++) begin : g_bit
        assign and_conn[m*N_LIT + 2*s]     = ((m >> s) & 1) != 0;
        assign and_conn[m*N_LIT + 2*s + 1] = ((m >> s) & 1) == 0;
      end
    end
  end else begin : g_and_prog
    assign and_conn = cfg_word[AND_BITS-1:0];
  end

  if (MODE == PLANE_PAL) begin : g_or_fixed
    for (genvar t = 0; t < NT; t++) begin : g_t
      for (genvar k = 0; k < N_OUT; k++) begin : g_k
        assign or_conn[t*N_OUT + k] = ((t % N_OUT) == k);
      end
    end
  end else begin : g_or_prog
    assign or_conn = cfg_word[AND_BITS +: OR_BITS];
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_drive
    if (k < N_IO) begin : g_pin
      assign drive_en[k] = loaded & en_bits[k];
    end else begin : g_ded
      assign drive_en[k] = loaded;
    end
  end

  for (genvar j = 0; j < N_IO; j++) begin : g_src
    assign pin_src[j] = drive_en[j] ? fb_q[j] : pin_di[j];
  end

  assign src = {pin_src, ded_in};

  pla_and_plane #(.N_SRC(N_SRC), .NT(NT)) u_and (
    .src  (src),
    .conn (and_conn),
    .term (term)
  );

  pla_or_plane #(.NT(NT), .N_OUT(N_OUT)) u_or (
    .term (term),
    .conn (or_conn),
    .pol  (pol_bits),
    .f    (f_val)
  );

  assign pin_oe = drive_en;
  assign pin_do = f_val & drive_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fb_q <= '0;
    else        fb_q <= pin_do[N_IO-1:0];
  end

  AST_HIZ_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> (pin_oe == '0 && pin_do == '0)); // R2
endmodule

// File: tb/tb_pla_array.sv
module tb_pla_array;
  import pla_pkg::*;

  localparam int LEN_A = 125;
  localparam int LEN_R = 197;
  localparam int LEN_P = 101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_a = 1'b0, bt_a = 1'b0;
  logic ld_r = 1'b0, bt_r = 1'b0;
  logic ld_p = 1'b0, bt_p = 1'b0;
  logic [3:0] din = '0;
  logic [1:0] pdi = '0;
  logic [2:0] do_a, oe_a, do_r, oe_r, do_p, oe_p;
  logic [255:0] cv;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pla_array dut (.clk(clk), .rst_n(rst_n), .cfg_load(ld_a), .cfg_bit(bt_a),
    .ded_in(din), .pin_di(pdi), .pin_do(do_a), .pin_oe(oe_a));
  pla_array #(.MODE(PLANE_ROM)) dut_rom (.clk(clk), .rst_n(rst_n), .cfg_load(ld_r),
    .cfg_bit(bt_r), .ded_in(din), .pin_di(pdi), .pin_do(do_r), .pin_oe(oe_r));
  pla_array #(.MODE(PLANE_PAL)) dut_pal (.clk(clk), .rst_n(rst_n), .cfg_load(ld_p),
    .cfg_bit(bt_p), .ded_in(din), .pin_di(pdi), .pin_do(do_p), .pin_oe(oe_p));

  function automatic int ai(int t, int s, int n);
    return t * 12 + 2 * s + n;
  endfunction

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    ld_a = 0; ld_r = 0; ld_p = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic shift_cfg(int which, logic [255:0] v, int hi, int lo);
    for (int i = hi; i >= lo; i--) begin
      @(negedge clk);
      case (which)
        0: begin ld_a = 1; bt_a = v[i]; end
        1: begin ld_r = 1; bt_r = v[i]; end
        default: begin ld_p = 1; bt_p = v[i]; end
      endcase
    end
    @(negedge clk);
    ld_a = 0; ld_r = 0; ld_p = 0;
  endtask

  // Scenario: reset state, partial load, full load, shared term, polarity, disabled pin
  task automatic t_comb_pla();
    do_reset();
    #1;
    chk("R2 reset oe", oe_a | oe_r | oe_p, 3'b000);
    chk("R2 reset do", do_a | do_r | do_p, 3'b000);
    cv = '0;
    cv[ai(0,0,0)] = 1; cv[ai(0,1,0)] = 1;           // t0 = d0 & d1
    cv[ai(1,2,1)] = 1;                              // t1 = ~d2
    cv[ai(3,3,0)] = 1; cv[ai(3,5,0)] = 1;           // t3 = d3 & pin1
    cv[96+0*3+0] = 1; cv[96+1*3+0] = 1; cv[96+2*3+0] = 1;
    cv[96+0*3+2] = 1; cv[96+3*3+2] = 1;
    cv[120+2] = 1;                                  // invert output 2
    cv[123] = 1;                                    // pin0 driven, pin1 not
    shift_cfg(0, cv, LEN_A-1, 1);
    #1;
    chk("R2 one bit short oe", oe_a, 3'b000);
    shift_cfg(0, cv, 0, 0);
    for (int d = 0; d < 16; d++) begin
      for (int p = 0; p < 4; p++) begin
        logic [2:0] e;
        @(negedge clk);
        din = 4'(d); pdi = 2'(p);
        #1;
        e[0] = (din[0] & din[1]) | ~din[2];
        e[1] = 1'b0;
        e[2] = ~((din[0] & din[1]) | (din[3] & pdi[1]));
        chk("R4 R5 R6 R8 function", do_a, e);
        chk("R7 enables", oe_a, 3'b101);
      end
    end
    // R3: toggling cfg_bit with cfg_load low changes nothing
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      bt_a = ~bt_a;
    end
    din = 4'b0011; pdi = 2'b10;
    #1;
    chk("R3 idle shift ignored", do_a, 3'b001);
    chk("R3 idle oe", oe_a, 3'b101);
  endtask

  // Scenario: feedback from a driven pin arrives one edge later
  task automatic t_feedback();
    do_reset();
    cv = '0;
    cv[ai(0,0,0)] = 1;                              // t0 = d0
    cv[ai(1,4,0)] = 1; cv[ai(1,1,0)] = 1;           // t1 = pin0 & d1
    cv[96+0*3+0] = 1; cv[96+1*3+1] = 1;
    cv[123] = 1; cv[124] = 1;
    din = '0; pdi = 2'b01;
    shift_cfg(0, cv, LEN_A-1, 0);
    @(negedge clk);
    @(negedge clk);
    din = 4'b0011; pdi = 2'b00;
    #1;
    chk("R9 feedback not yet", do_a, 3'b001);
    chk("R7 all driven", oe_a, 3'b011 | 3'b100);
    @(negedge clk); #1;
    chk("R9 feedback arrives", do_a, 3'b011);
    @(negedge clk);
    din = 4'b0010;
    #1;
    chk("R9 feedback lags", do_a, 3'b010);
    @(negedge clk); #1;
    chk("R9 feedback clears", do_a, 3'b000);
    pdi = 2'b11;
    @(negedge clk); #1;
    chk("R9 pin_di ignored", do_a, 3'b000);
  endtask

  // Scenario: decoder mode
  task automatic t_rom();
    do_reset();
    cv = '0;
    for (int m = 0; m < 64; m++) if (m % 3 == 0) cv[m*3+2] = 1;
    cv[192+2] = 1;                                  // invert output 2
    shift_cfg(1, cv, LEN_R-1, 0);
    for (int m = 0; m < 64; m++) begin
      @(negedge clk);
      din = 4'(m); pdi = 2'(m >> 4);
      #1;
      chk("R10 minterm", do_r, {(m % 3) != 0, 2'b00});
    end
    chk("R7 pins off", oe_r, 3'b100);
  endtask

  // Scenario: fixed OR grouping
  task automatic t_pal();
    do_reset();
    cv = '0;
    cv[ai(0,0,0)] = 1;                              // t0 -> out0: d0
    cv[ai(3,1,0)] = 1; cv[ai(3,2,1)] = 1;           // t3 -> out0: d1 & ~d2
    cv[ai(1,3,1)] = 1;                              // t1 -> out1: ~d3
    cv[ai(2,2,0)] = 1; cv[ai(2,3,0)] = 1;           // t2 -> out2: d2 & d3
    cv[96+1] = 1;                                   // invert output 1
    cv[99] = 1; cv[100] = 1;
    shift_cfg(2, cv, LEN_P-1, 0);
    for (int d = 0; d < 16; d++) begin
      logic [2:0] e;
      @(negedge clk);
      din = 4'(d);
      #1;
      e[0] = din[0] | (din[1] & ~din[2]);
      e[1] = din[3];
      e[2] = din[2] & din[3];
      chk("R11 fixed OR", do_p, e);
    end
    chk("R7 pal oe", oe_p, 3'b111);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_comb_pla();
    t_feedback();
    t_rom();
    t_pal();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule